// File: doc/BRIEF.md
# FLL Loss-of-Lock Monitor

This block decides whether a frequency-locked loop output is running at the intended multiple of a reference. It runs on the loop's own output clock. It counts output cycles across a fixed number of reference ticks and compares that count with an expected value and a tolerance. A two-bit clock mode selects the comparison reference. The two external-reference modes use the external tick. The two internal-reference modes use the internal tick.

A lock indicator follows the window results with a small amount of hysteresis. Whenever a window result drops the indicator from locked to unlocked, a sticky loss-of-lock status bit is set. Software clears that bit by writing one to it. An interrupt enable, loaded through the same write port, gates the interrupt line. A change of clock mode restarts the measurement and forces the indicator to unlocked without raising the status.

Top module: `fll_lock_monitor`

## Requirements
- R1: Mode codes 1 and 3 (bit 0 set) use `extRefTick` as reference; codes 0 and 2 use `intRefTick`; ticks on the unselected input have no effect on the measurement.
- R2: Both tick inputs pass through a two-flop synchronizer and a rising-edge detector. After a mode change or reset, the first reference edge opens a window. Every N_REF further edges close it. The count of `fllClk` cycles between the opening and closing edges is in tolerance when it lies within EXP_CNT-TOL to EXP_CNT+TOL inclusive. The closing edge opens the next window.
- R3: `locked` rises on the second consecutive in-tolerance window and falls on any out-of-tolerance window.
- R4: `lolStatus` is set when a window result turns `locked` from 1 to 0; further out-of-tolerance windows while already unlocked do not set it again.
- R5: `lolIrq` is 1 exactly while `lolStatus` is 1 and the interrupt enable is 1.
- R6: A write (`wrEn`=1) loads the interrupt enable from `wrIe`; with `wrClr`=1 it clears a set `lolStatus`, with `wrClr`=0 the status is left unchanged.
- R7: A change of `modeSel` forces `locked` to 0 and discards the window in progress; it does not set `lolStatus`.
- R8: When a status set event and a clearing write fall in the same cycle, `lolStatus` ends at 1.
- R9: Reset drives `locked`, `lolStatus`, the interrupt enable and `lolIrq` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fllClk | input | 1 | FLL output clock; clocks the whole block |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Clock mode code; bit 0 picks external reference |
| extRefTick | input | 1 | External reference tick, asynchronous |
| intRefTick | input | 1 | Internal reference tick, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrClr | input | 1 | Write data: 1 clears the loss-of-lock status |
| wrIe | input | 1 | Write data: interrupt enable value |
| locked | output | 1 | Lock indicator |
| lolStatus | output | 1 | Sticky loss-of-lock status |
| lolIrq | output | 1 | Loss-of-lock interrupt |

## Verification
The bench builds the block with N_REF=4, EXP_CNT=64, TOL=4 and CNT_W=8. Window counts are then four times the tick period. Periods of 15 and 17 land exactly on the inclusive tolerance edges, and 14 and 18 fall just outside them. A window lasts under 80 cycles, so a single run covers many lock, unlock and relock sequences in all four modes. Clearing writes are also timed to fall on the exact cycle of a set event.

// File: rtl/fll_lock_pkg.sv
package fll_lock_pkg;

  typedef enum logic [1:0] {
    MODE_INT_ENGAGED = 2'd0,
    MODE_EXT_ENGAGED = 2'd1,
    MODE_INT_BYPASS  = 2'd2,
    MODE_EXT_BYPASS  = 2'd3
  } clkMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clearWin;
    logic useExt;
  } ctrlStrobe_t;

  // datapath -> control results
  typedef struct packed {
    logic winDone;
    logic inTol;
  } winStat_t;

endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import fll_lock_pkg::*;
#(
  parameter int N_REF   = 8,
  parameter int EXP_CNT = 512,
  parameter int TOL     = 8,
  parameter int CNT_W   = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extRefTick,
  input  logic        intRefTick,
  input  ctrlStrobe_t ctrl,
  output winStat_t    stat
);

  localparam int REF_W = (N_REF > 1) ? $clog2(N_REF) : 1;
  localparam int LO_I  = (EXP_CNT > TOL) ? EXP_CNT - TOL : 0;
  localparam int HI_I  = EXP_CNT + TOL;
  localparam logic [CNT_W:0] LO_V = (CNT_W + 1)'(LO_I);
  localparam logic [CNT_W:0] HI_V = (CNT_W + 1)'(HI_I);
  localparam logic [REF_W-1:0] LAST_REF = REF_W'(N_REF - 1);

  logic [1:0] syncExt, syncInt;
  logic       refPrev, selRef, refEdge;
  logic       armed;
  logic [REF_W-1:0] refCnt;
  logic [CNT_W-1:0] cycCnt;
  logic [CNT_W:0]   measured;
  logic             lastEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncExt <= '0;
      syncInt <= '0;
      refPrev <= 1'b0;
    end else begin
      syncExt <= {syncExt[0], extRefTick};
      syncInt <= {syncInt[0], intRefTick};
      refPrev <= selRef;
    end
  end

  assign selRef   = ctrl.useExt ? syncExt[1] : syncInt[1];
  assign refEdge  = selRef & ~refPrev;
  assign lastEdge = armed & refEdge & (refCnt == LAST_REF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      refCnt <= '0;
      cycCnt <= '0;
    end else if (ctrl.clearWin) begin
      armed  <= 1'b0;
      refCnt <= '0;
      cycCnt <= '0;
    end else if (refEdge && !armed) begin
      armed  <= 1'b1;
      refCnt <= '0;
      cycCnt <= '0;
    end else if (lastEdge) begin
      refCnt <= '0;
      cycCnt <= '0;
    end else begin
      if (refEdge) refCnt <= refCnt + 1'b1;
      if (cycCnt != '1) cycCnt <= cycCnt + 1'b1;
    end
  end

  assign measured     = {1'b0, cycCnt} + 1'b1;
  assign stat.winDone = lastEdge & ~ctrl.clearWin;
  assign stat.inTol   = (measured >= LO_V) && (measured <= HI_V);

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import fll_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic        wrEn,
  input  logic        wrClr,
  input  logic        wrIe,
  input  winStat_t    stat,
  output ctrlStrobe_t ctrl,
  output logic        locked,
  output logic        lolStatus,
  output logic        lolIrq
);

  logic [1:0] modePrev;
  logic       modeChg;
  logic       goodStreak;
  logic       lockedR;
  logic       statusR;
  logic       intEn;
  logic       lolSet;

  assign modeChg       = (modeSel != modePrev);
  assign ctrl.clearWin = modeChg;
  assign ctrl.useExt   = modeSel[0];
  assign lolSet        = !modeChg && stat.winDone && !stat.inTol && lockedR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev   <= MODE_INT_ENGAGED;
      goodStreak <= 1'b0;
      lockedR    <= 1'b0;
      statusR    <= 1'b0;
      intEn      <= 1'b0;
    end else begin
      modePrev <= modeSel;
      if (modeChg) begin
        lockedR    <= 1'b0;
        goodStreak <= 1'b0;
      end else if (stat.winDone) begin
        if (stat.inTol) begin
          lockedR    <= lockedR | goodStreak;
          goodStreak <= 1'b1;
        end else begin
          lockedR    <= 1'b0;
          goodStreak <= 1'b0;
        end
      end
      if (wrEn) intEn <= wrIe;
      if (lolSet) statusR <= 1'b1;
      else if (wrEn && wrClr && statusR) statusR <= 1'b0;
    end
  end

  assign locked    = lockedR;
  assign lolStatus = statusR;
  assign lolIrq    = statusR & intEn;

endmodule

// File: rtl/fll_lock_monitor.sv
module fll_lock_monitor
  import fll_lock_pkg::*;
#(
  parameter int N_REF   = 8,
  parameter int EXP_CNT = 512,
  parameter int TOL     = 8,
  parameter int CNT_W   = 12
) (
  input  logic       fllClk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       extRefTick,
  input  logic       intRefTick,
  input  logic       wrEn,
  input  logic       wrClr,
  input  logic       wrIe,
  output logic       locked,
  output logic       lolStatus,
  output logic       lolIrq
);

  ctrlStrobe_t ctrl;
  winStat_t    dpStat;

  lock_datapath #(
    .N_REF(N_REF), .EXP_CNT(EXP_CNT), .TOL(TOL), .CNT_W(CNT_W)
  ) u_dp (
    .clk(fllClk), .rstN(rstN),
    .extRefTick(extRefTick), .intRefTick(intRefTick),
    .ctrl(ctrl), .stat(dpStat)
  );

  lock_ctrl u_ctrl (
    .clk(fllClk), .rstN(rstN), .modeSel(modeSel),
    .wrEn(wrEn), .wrClr(wrClr), .wrIe(wrIe),
    .stat(dpStat), .ctrl(ctrl),
    .locked(locked), .lolStatus(lolStatus), .lolIrq(lolIrq)
  );

endmodule

// File: rtl/lock_monitor_chk.sv
module lock_monitor_chk
  import fll_lock_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       wrEn,
  input logic       wrClr,
  input logic       locked,
  input logic       lolStatus,
  input logic       lolIrq,
  input winStat_t   dpStat
);

  // R3
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(dpStat.winDone && dpStat.inTol));

  // R4
  status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lolStatus) |-> ($past(locked) && !locked));

  // R5
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    lolIrq |-> lolStatus);

  // R6
  zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrClr && lolStatus) |=> lolStatus);

  // R7
  mode_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != $past(modeSel)) |=> !locked);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.winDone && !dpStat.inTol && locked && wrEn && wrClr) |=> lolStatus);

endmodule

bind fll_lock_monitor lock_monitor_chk u_chk (
  .clk(fllClk), .rstN(rstN), .modeSel(modeSel), .wrEn(wrEn), .wrClr(wrClr),
  .locked(locked), .lolStatus(lolStatus), .lolIrq(lolIrq), .dpStat(dpStat)
);

// File: tb/tb_fll_lock_monitor.sv
module tb_fll_lock_monitor;

  localparam int N   = 4;
  localparam int EXP = 64;
  localparam int TL  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic extT = 1'b0, intT = 1'b0;
  logic wrEn = 1'b0, wrClr = 1'b0, wrIe = 1'b0;
  logic locked, lolStatus, lolIrq;

  int checks = 0;
  int fails = 0;
  bit eLocked = 0, eStreak = 0, eStat = 0, eIe = 0;
  int pending = 0;

  always #10 clk = ~clk;

  fll_lock_monitor #(.N_REF(N), .EXP_CNT(EXP), .TOL(TL), .CNT_W(8)) dut (
    .fllClk(clk), .rstN(rstN), .modeSel(mode),
    .extRefTick(extT), .intRefTick(intT),
    .wrEn(wrEn), .wrClr(wrClr), .wrIe(wrIe),
    .locked(locked), .lolStatus(lolStatus), .lolIrq(lolIrq)
  );

  function automatic bit inTolF(int meas);
    return (meas >= EXP - TL) && (meas <= EXP + TL);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // model of one closed window, with an optional coincident clearing write
  task automatic closeWindow(bit clrNow);
    bit setEv = 0;
    if (pending > 0) begin
      if (inTolF(N * pending)) begin
        eLocked = eLocked | eStreak;
        eStreak = 1;
      end else begin
        setEv   = eLocked;
        eLocked = 0;
        eStreak = 0;
      end
    end
    if (setEv) eStat = 1;
    else if (clrNow) eStat = 0;
  endtask

  task automatic runWindow(int p, bit clrAtEnd, bit doWr, bit wClr, bit wIe);
    for (int i = 0; i < N; i++) begin
      if (mode[0]) extT = 1'b1; else intT = 1'b1;
      @(negedge clk);
      extT = 1'b0; intT = 1'b0;
      for (int j = 1; j < p; j++) begin
        @(negedge clk);
        if (i == 0) begin
          if (j == 1 && clrAtEnd) begin
            wrEn = 1'b1; wrClr = 1'b1; wrIe = eIe;
          end
          if (j == 2) begin
            wrEn = 1'b0;
            if (pending > 0) begin
              closeWindow(clrAtEnd);
              chk($sformatf("R3 locked, R1 mode %0d", mode), locked, eLocked);
              chk(clrAtEnd ? "R8 status set vs clear" : "R4 status", lolStatus, eStat);
              chk("R5 irq", lolIrq, eStat & eIe);
            end else if (clrAtEnd) begin
              eStat = 0;
            end
            pending = p;
          end
          if (j == 3 && doWr) begin
            wrEn = 1'b1; wrClr = wClr; wrIe = wIe;
          end
          if (j == 4 && doWr) begin
            wrEn = 1'b0;
            eIe = wIe;
            if (wClr) eStat = 0;
          end
          if (j == 5 && doWr) begin
            chk("R6 status after write", lolStatus, eStat);
            chk("R6 irq after write", lolIrq, eStat & eIe);
          end
        end
        if (j == 6) begin
          if (mode[0]) intT = 1'b1; else extT = 1'b1;
        end
        if (j == 7) begin
          intT = 1'b0; extT = 1'b0;
        end
      end
    end
  endtask

  task automatic changeMode(logic [1:0] m);
    mode = m;
    eLocked = 0; eStreak = 0; pending = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 locked after mode change", locked, 1'b0);
    chk("R7 status after mode change", lolStatus, eStat);
  endtask

  task automatic writeIdle(bit wClr, bit wIe);
    wrEn = 1'b1; wrClr = wClr; wrIe = wIe;
    @(negedge clk);
    wrEn = 1'b0;
    eIe = wIe;
    if (wClr) eStat = 0;
    @(negedge clk);
    chk("R6 idle write irq", lolIrq, eStat & eIe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 locked reset", locked, 1'b0);
    chk("R9 status reset", lolStatus, 1'b0);
    chk("R9 irq reset", lolIrq, 1'b0);

    writeIdle(0, 1);
    runWindow(16, 0, 0, 0, 0);   // arms
    runWindow(16, 0, 0, 0, 0);   // one good: still unlocked
    runWindow(16, 0, 0, 0, 0);   // two good: locked
    runWindow(17, 0, 0, 0, 0);
    runWindow(15, 0, 0, 0, 0);   // closes 68 (R2 upper edge)
    runWindow(18, 0, 0, 0, 0);   // closes 60 (R2 lower edge)
    runWindow(14, 0, 1, 1, 1);   // closes 72: unlock + set, then clear
    runWindow(13, 0, 0, 0, 0);   // closes 56: no new set
    runWindow(16, 0, 0, 0, 0);   // closes 52
    runWindow(16, 0, 0, 0, 0);
    runWindow(19, 0, 0, 0, 0);   // relocked
    runWindow(16, 1, 1, 0, 0);   // closes 76 with clear in same cycle; then write-0 ie=0
    runWindow(16, 0, 1, 1, 1);
    runWindow(16, 0, 0, 0, 0);
    runWindow(16, 0, 0, 0, 0);
    changeMode(2'd3);
    runWindow(16, 0, 0, 0, 0);
    runWindow(16, 0, 0, 0, 0);
    runWindow(16, 0, 0, 0, 0);
    runWindow(16, 0, 0, 0, 0);

    for (int k = 0; k < 48; k++) begin
      int p;
      p = 13 + int'($urandom % 7);
      runWindow(p, ($urandom % 6) == 0, ($urandom % 4) == 0,
                bit'($urandom % 2), bit'($urandom % 2));
      if (k % 12 == 11) changeMode(2'((int'(mode) + 1 + int'($urandom % 3)) % 4));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule